// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller built from a parameterised number of banks. Each bank holds up to 32 pins, and a bank may be configured with fewer pins. For every bank, software can program the output values, the pin direction, open-drain behaviour, the interrupt trigger type, an interrupt enable and a sticky event register.

Pin inputs pass through a two-flop synchroniser. Each pin can flag an event on a rising edge, a falling edge, either edge, a high level or a low level. Events are recorded whether or not the pin is enabled. A combined interrupt line reports any enabled event in any bank. A separate wake line reports any recorded event at all, enabled or not.

The register port is one word wide and uses word addresses. Reads are combinational. A write takes effect at the next clock edge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, except the direction register, which reads 1 on every implemented pin. `irq_o` and `wake_o` are low.
- R2: Register r of bank b sits at word address b*8+r. The order for r = 0..7 is: open-drain, data, direction, polarity select, any-edge, enable, level select, event. Each configuration register reads back the value written to it.
- R3: Bits at or above a bank's configured width read 0 in every register. They never record an event and never drive a pin.
- R4: A direction bit of 1 makes the pin an input (`pin_oe`=0). With direction 0 and open-drain 0, `pin_oe`=1 and `pin_out` equals the data bit.
- R5: With direction 0 and open-drain 1, the pin drives low (`pin_oe`=1, `pin_out`=0) for data 0 and is released (`pin_oe`=0) for data 1.
- R6: Reading the data register returns the synchronised pin level for input pins and the written value for output pins.
- R7: With level select 0 and any-edge 0, polarity select 1 records rising edges only and polarity select 0 records falling edges only.
- R8: With level select 0 and any-edge 1, both edges are recorded, whatever the polarity select bit holds.
- R9: With level select 1, polarity select 1 records a high level and 0 records a low level. The event bit sets again on every cycle the level persists, so clearing it has no lasting effect.
- R10: Writing 1 to an event bit clears it and writing 0 leaves it unchanged. An event in the same cycle as the clear wins.
- R11: Event bits record while their enable bit is 0. `irq_o` is the OR over all banks of event AND enable.
- R12: `wake_o` is the OR of all event bits of all banks, regardless of enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address (bank*8 + register) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pin_in | input | NUM_BANKS*32 | Pin levels from the pads |
| pin_out | output | NUM_BANKS*32 | Output value per pin |
| pin_oe | output | NUM_BANKS*32 | Output enable per pin |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Any recorded event |

## Verification
The bench builds two banks. Bank 0 is a full 32 pins wide and bank 1 is 20 pins wide. This lets the bench check the masking of unimplemented bits within one bank while the other bank stays fully populated. It also lets it check that interrupts combine across more than one bank. With two banks the address decode covers the bank-index field, so a write that reaches the wrong bank shows up as a mismatch with the reference model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PINS_PER_BANK = 32;
  localparam int REGS_PER_BANK = 8;
  localparam int WIDTH_FIELD_W = 6;

  // Register index inside a bank; the order is fixed by the address map.
  typedef enum logic [2:0] {
    REG_ODRAIN   = 3'd0,
    REG_OUTVAL   = 3'd1,
    REG_INMODE   = 3'd2,
    REG_POLSEL   = 3'd3,
    REG_ANYEDGE  = 3'd4,
    REG_ENABLE   = 3'd5,
    REG_LEVELSEL = 3'd6,
    REG_EVENT    = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int          W     = 32,
  parameter logic [31:0] VMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] sel_lvl,
  input  logic [W-1:0] sel_pol,
  input  logic [W-1:0] sel_any,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, lvl_hit, edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  always_comb begin
    rise     = cur & ~prev_q;
    fall     = ~cur & prev_q;
    lvl_hit  = (sel_pol & cur) | (~sel_pol & ~cur);
    edge_hit = (sel_any & (rise | fall)) |
               (~sel_any & ((sel_pol & rise) | (~sel_pol & fall)));
    hit      = VMASK[W-1:0] & ((sel_lvl & lvl_hit) | (~sel_lvl & edge_hit));
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int BW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  gpio_reg_e                reg_sel,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  input  logic [PINS_PER_BANK-1:0] pin_in,
  output logic [PINS_PER_BANK-1:0] pin_out,
  output logic [PINS_PER_BANK-1:0] pin_oe,
  output logic                     pend,
  output logic                     any_evt
);
  localparam logic [31:0] VMASK = (BW >= 32) ? 32'hFFFF_FFFF : ((32'd1 << BW) - 32'd1);

  logic [31:0] odrain_q, odrain_d;
  logic [31:0] outval_q, outval_d;
  logic [31:0] inmode_q, inmode_d;
  logic [31:0] polsel_q, polsel_d;
  logic [31:0] anyedge_q, anyedge_d;
  logic [31:0] enable_q, enable_d;
  logic [31:0] levelsel_q, levelsel_d;
  logic [31:0] event_q, event_d;
  logic [31:0] clr_bits;
  logic [31:0] pin_sync;
  logic [31:0] hit;
  logic        cfg_we;

  gpio_sync #(.W(PINS_PER_BANK)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_detect #(.W(PINS_PER_BANK), .VMASK(VMASK)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur     (pin_sync),
    .sel_lvl (levelsel_q),
    .sel_pol (polsel_q),
    .sel_any (anyedge_q),
    .hit     (hit)
  );

  assign cfg_we = wr_en && (reg_sel != REG_EVENT);

  always_comb begin
    odrain_d   = odrain_q;
    outval_d   = outval_q;
    inmode_d   = inmode_q;
    polsel_d   = polsel_q;
    anyedge_d  = anyedge_q;
    enable_d   = enable_q;
    levelsel_d = levelsel_q;
    clr_bits   = '0;
    if (wr_en) begin
      case (reg_sel)
        REG_ODRAIN:   odrain_d   = wdata & VMASK;
        REG_OUTVAL:   outval_d   = wdata & VMASK;
        REG_INMODE:   inmode_d   = wdata & VMASK;
        REG_POLSEL:   polsel_d   = wdata & VMASK;
        REG_ANYEDGE:  anyedge_d  = wdata & VMASK;
        REG_ENABLE:   enable_d   = wdata & VMASK;
        REG_LEVELSEL: levelsel_d = wdata & VMASK;
        default:      clr_bits   = wdata;
      endcase
    end
    // A new event takes priority over a simultaneous clear.
    event_d = ((event_q & ~clr_bits) | hit) & VMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odrain_q   <= '0;
      outval_q   <= '0;
      inmode_q   <= VMASK;
      polsel_q   <= '0;
      anyedge_q  <= '0;
      enable_q   <= '0;
      levelsel_q <= '0;
      event_q    <= '0;
    end else begin
      if (cfg_we) begin
        odrain_q   <= odrain_d;
        outval_q   <= outval_d;
        inmode_q   <= inmode_d;
        polsel_q   <= polsel_d;
        anyedge_q  <= anyedge_d;
        enable_q   <= enable_d;
        levelsel_q <= levelsel_d;
      end
      event_q <= event_d;
    end
  end

  always_comb begin
    case (reg_sel)
      REG_ODRAIN:   rdata = odrain_q;
      REG_OUTVAL:   rdata = ((inmode_q & pin_sync) | (~inmode_q & outval_q)) & VMASK;
      REG_INMODE:   rdata = inmode_q;
      REG_POLSEL:   rdata = polsel_q;
      REG_ANYEDGE:  rdata = anyedge_q;
      REG_ENABLE:   rdata = enable_q;
      REG_LEVELSEL: rdata = levelsel_q;
      default:      rdata = event_q;
    endcase
  end

  assign pin_out = outval_q & ~odrain_q;
  assign pin_oe  = VMASK & ~inmode_q & (~odrain_q | ~outval_q);
  assign pend    = |(event_q & enable_q);
  assign any_evt = |event_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int                                NUM_BANKS   = 2,
  parameter logic [NUM_BANKS*WIDTH_FIELD_W-1:0] BANK_WIDTHS = {6'd20, 6'd32},
  localparam int ADDR_W   = $clog2(NUM_BANKS * REGS_PER_BANK),
  localparam int TOT_PINS = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [TOT_PINS-1:0] pin_in,
  output logic [TOT_PINS-1:0] pin_out,
  output logic [TOT_PINS-1:0] pin_oe,
  output logic                irq_o,
  output logic                wake_o
);
  logic [31:0]          bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pend;
  logic [NUM_BANKS-1:0] bank_evt;
  gpio_reg_e            reg_sel;
  int unsigned          bank_idx;

  assign reg_sel  = gpio_reg_e'(addr[2:0]);
  assign bank_idx = int'(addr >> 3);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BW = int'(BANK_WIDTHS[b*WIDTH_FIELD_W +: WIDTH_FIELD_W]);
    logic bank_we;
    assign bank_we = wr_en && (bank_idx == b);

    gpio_bank #(.BW(BW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_we),
      .reg_sel (reg_sel),
      .wdata   (wdata),
      .rdata   (bank_rd[b]),
      .pin_in  (pin_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pin_out (pin_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pin_oe  (pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pend    (bank_pend[b]),
      .any_evt (bank_evt[b])
    );
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == b) rdata = bank_rd[b];
    end
  end

  assign irq_o  = |bank_pend;
  assign wake_o = |bank_evt;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int                                NUM_BANKS   = 2,
  parameter logic [NUM_BANKS*WIDTH_FIELD_W-1:0] BANK_WIDTHS = {6'd20, 6'd32},
  parameter int                                ADDR_W      = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              wr_en,
  input logic [ADDR_W-1:0]                 addr,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_out,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_oe,
  input logic                              irq_o,
  input logic                              wake_o
);
  function automatic logic [NUM_BANKS*PINS_PER_BANK-1:0] unimpl_mask();
    logic [NUM_BANKS*PINS_PER_BANK-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      for (int i = 0; i < PINS_PER_BANK; i++)
        if (i >= int'(BANK_WIDTHS[b*WIDTH_FIELD_W +: WIDTH_FIELD_W]))
          m[b*PINS_PER_BANK + i] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_BANKS*PINS_PER_BANK-1:0] UNIMPL = unimpl_mask();

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!irq_o && !wake_o));

  // R3
  unimpl_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & UNIMPL) == '0);

  // R10
  event_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_o) |-> $past(wr_en && (addr[2:0] == 3'd7)));

  // R4
  oe_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(wr_en));

  // R5
  out_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> $past(wr_en));

  // R11
  irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> wake_o);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_BANKS   (NUM_BANKS),
  .BANK_WIDTHS (BANK_WIDTHS),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .irq_o   (irq_o),
  .wake_o  (wake_o)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq_o, wake_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_BANKS(2), .BANK_WIDTHS({6'd20, 6'd32})) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  // ---------------- behavioural reference model ----------------
  int          m_width [NB] = '{32, 20};
  logic [31:0] m_od [NB], m_dat [NB], m_dir [NB], m_pol [NB], m_any [NB];
  logic [31:0] m_en [NB], m_lvl [NB], m_evt [NB];
  logic [31:0] m_s1 [NB], m_s2 [NB], m_pv [NB];

  function automatic logic [31:0] vm(input int b);
    return (m_width[b] >= 32) ? 32'hFFFF_FFFF : ((32'd1 << m_width[b]) - 1);
  endfunction

  task automatic m_reset();
    for (int b = 0; b < NB; b++) begin
      m_od[b] = 0; m_dat[b] = 0; m_dir[b] = vm(b); m_pol[b] = 0; m_any[b] = 0;
      m_en[b] = 0; m_lvl[b] = 0; m_evt[b] = 0; m_s1[b] = 0; m_s2[b] = 0; m_pv[b] = 0;
    end
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      for (int b = 0; b < NB; b++) begin
        logic [31:0] hit, clr, v;
        hit = 0;
        for (int i = 0; i < m_width[b]; i++) begin
          bit s, p;
          s = m_s2[b][i]; p = m_pv[b][i];
          if (m_lvl[b][i])      hit[i] = m_pol[b][i] ? s : !s;
          else if (m_any[b][i]) hit[i] = (s != p);
          else if (m_pol[b][i]) hit[i] = s && !p;
          else                  hit[i] = !s && p;
        end
        clr = 0;
        v = wdata & vm(b);
        if (wr_en && int'(addr >> 3) == b) begin
          case (addr[2:0])
            0: m_od[b] = v;  1: m_dat[b] = v; 2: m_dir[b] = v; 3: m_pol[b] = v;
            4: m_any[b] = v; 5: m_en[b] = v;  6: m_lvl[b] = v; default: clr = wdata;
          endcase
        end
        m_evt[b] = ((m_evt[b] & ~clr) | hit) & vm(b);
        m_pv[b] = m_s2[b];
        m_s2[b] = m_s1[b];
        m_s1[b] = pin_in[b*32 +: 32];
      end
    end
  end

  function automatic logic [31:0] m_rd(input logic [3:0] a);
    int b;
    b = int'(a >> 3);
    case (a[2:0])
      0: return m_od[b];
      1: return ((m_dir[b] & m_s2[b]) | (~m_dir[b] & m_dat[b])) & vm(b);
      2: return m_dir[b];
      3: return m_pol[b];
      4: return m_any[b];
      5: return m_en[b];
      6: return m_lvl[b];
      default: return m_evt[b];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [NP-1:0] e_out, e_oe;
      logic e_irq, e_wake;
      e_irq = 0; e_wake = 0;
      for (int b = 0; b < NB; b++) begin
        e_out[b*32 +: 32] = m_dat[b] & ~m_od[b];
        e_oe[b*32 +: 32]  = vm(b) & ~m_dir[b] & (~m_od[b] | ~m_dat[b]);
        e_irq  |= |(m_evt[b] & m_en[b]);
        e_wake |= |m_evt[b];
      end
      chk("R2 rdata", 64'(rdata), 64'(m_rd(addr)));
      chk("R4 pin_out", pin_out, e_out);
      chk("R5 pin_oe", pin_oe, e_oe);
      chk("R11 irq_o", 64'(irq_o), 64'(e_irq));
      chk("R12 wake_o", 64'(wake_o), 64'(e_wake));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, 64'(rdata), 64'(exp));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    // R1 reset state
    rd_chk("R1 dir bank0", 4'd2, 32'hFFFF_FFFF);
    rd_chk("R1 event bank0", 4'd7, 32'h0);
    rd_chk("R1 mask bank1", 4'd13, 32'h0);
    chk("R1 irq_o", 64'(irq_o), 64'd0);
    // R3 narrow bank
    rd_chk("R3 dir bank1", 4'd10, 32'h000F_FFFF);
    wr(4'd11, 32'hFFFF_FFFF);
    rd_chk("R3 pol bank1", 4'd11, 32'h000F_FFFF);
    // R2 read back
    wr(4'd6, 32'h1234_0000);
    rd_chk("R2 levelsel bank0", 4'd6, 32'h1234_0000);
    wr(4'd6, 32'h0);
    // R4 / R5 outputs
    wr(4'd2, 32'hFFFF_0000);
    wr(4'd1, 32'h0000_00AA);
    wr(4'd0, 32'h0000_000F);
    wait_cyc(1);
    chk("R5 oe low half", 64'(pin_oe[15:0]), 64'h FFF5);
    chk("R4 out low byte", 64'(pin_out[7:0]), 64'hA0);
    chk("R4 inputs undriven", 64'(pin_oe[31:16]), 64'h0);
    // R6 data readback
    pin_in[31] = 1; pin_in[16] = 1; pin_in[0] = 1;
    wait_cyc(3);
    rd_chk("R6 data mix", 4'd1, 32'h8001_00AA);
    // R7 edge types
    wr(4'd3, 32'h0001_0000);
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd5, 32'h0003_0000);
    pin_in[16] = 0; wait_cyc(4);
    rd_chk("R7 falling on rising pin", 4'd7, 32'h0);
    pin_in[16] = 1; wait_cyc(4);
    rd_chk("R7 rising", 4'd7, 32'h0001_0000);
    chk("R11 irq set", 64'(irq_o), 64'd1);
    pin_in[17] = 1; wait_cyc(4);
    pin_in[17] = 0; wait_cyc(4);
    rd_chk("R7 falling", 4'd7, 32'h0003_0000);
    // R10 write-one-to-clear
    wr(4'd7, 32'h0001_0000);
    rd_chk("R10 clear one", 4'd7, 32'h0002_0000);
    wr(4'd7, 32'h0);
    rd_chk("R10 zero keeps", 4'd7, 32'h0002_0000);
    wr(4'd7, 32'hFFFF_FFFF);
    rd_chk("R10 clear all", 4'd7, 32'h0);
    chk("R10 irq low", 64'(irq_o), 64'd0);
    // R8 both edges, polarity bit set and ignored
    wr(4'd12, 32'h1);
    pin_in[32] = 1; wait_cyc(4);
    rd_chk("R8 rise", 4'd15, 32'h1);
    wr(4'd15, 32'h1);
    pin_in[32] = 0; wait_cyc(4);
    rd_chk("R8 fall", 4'd15, 32'h1);
    wr(4'd15, 32'h1);
    // R9 low level, then high level
    wr(4'd11, 32'h000F_FFFB);
    wr(4'd14, 32'h6);
    wait_cyc(2);
    rd_chk("R9 low level", 4'd15, 32'h4);
    pin_in[34] = 1; wait_cyc(4);
    wr(4'd15, 32'h4);
    rd_chk("R9 low level gone", 4'd15, 32'h0);
    pin_in[33] = 1; wait_cyc(4);
    rd_chk("R9 high level", 4'd15, 32'h2);
    chk("R12 wake while masked", 64'(wake_o), 64'd1);
    chk("R11 masked no irq", 64'(irq_o), 64'd0);
    wr(4'd15, 32'h2);
    rd_chk("R9 re-set", 4'd15, 32'h2);
    pin_in[33] = 0; wait_cyc(4);
    wr(4'd15, 32'h2);
    rd_chk("R9 cleared", 4'd15, 32'h0);
    // R3 unimplemented pins
    wr(4'd13, 32'hFFFF_FFFF);
    rd_chk("R3 mask bank1", 4'd13, 32'h000F_FFFF);
    pin_in[63:52] = '1; wait_cyc(4);
    rd_chk("R3 no high events", 4'd15, 32'h0);
    chk("R3 irq quiet", 64'(irq_o), 64'd0);
    chk("R3 bank1 undriven", 64'(pin_oe[63:32]), 64'h0);
    wait_cyc(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule